// File: doc/BRIEF.md
# Windowed Data Space Address Mapper

This block sits between a CPU data port and the memories behind it. Each cycle it takes a 16-bit byte address and decides which of four targets answers it. The targets are a low bank of peripheral control registers, directly mapped RAM, extended RAM and program memory. It drives one select line for the target it picks, a translated physical address and a write enable. It also routes the chosen target's read data back to the CPU.

The upper half of the address space (address bit 15 set) is a movable 32 KB window. A small window-configuration register chooses what the window shows. In one mode it shows a page of extended RAM. In the other mode it shows a page of program memory, where writes are not allowed. Only one page is visible at a time. Program memory is 24 bits wide. Through the window it appears as two 16-bit words per instruction, and the upper word reads back with its high byte forced to zero.

Decode is registered. A request presented in cycle N produces selects, physical address, write enable and error strobe in cycle N+1. Targets answer combinationally in that same cycle, so the CPU reads its data in cycle N+1.

Top module: `dspace_mapper`

## Requirements
- R1: While reset is held, and right after it, all selects, `mem_we`, `wr_err` and `cpu_rdata` are 0. The window starts in extended-RAM mode on page 0.
- R2: A request with address below `SFR_BYTES` (default 0x0800) asserts `sfr_sel` one cycle later. `phys_addr` equals the address zero-extended.
- R3: A request with address bit 15 clear and address at or above `SFR_BYTES` asserts `ram_sel` one cycle later. `phys_addr` equals the address zero-extended.
- R4: A request with address bit 15 set, made while the window mode is 0 (extended RAM), asserts `xram_sel` one cycle later, for reads and writes alike. `phys_addr` = {page, address[14:0]}.
- R5: A read with address bit 15 set, made while the window mode is 1 (program view), asserts `pgm_sel` one cycle later. `phys_addr` = {page, address[14:0]} and `mem_we` stays 0.
- R6: For a program-view read, `cpu_rdata` depends on address bit 1. When it is 0, `cpu_rdata` is `pgm_rdata[15:0]`. When it is 1, `cpu_rdata` is {8'h00, `pgm_rdata[23:16]`}.
- R7: A write with address bit 15 set, made while the window mode is 1, is ignored. No select and no `mem_we` are raised, and `wr_err` pulses high for exactly that one response cycle.
- R8: A window-configuration write applies from the next request on. A request presented in the same cycle as the configuration write still uses the old mode and page.
- R9: At most one select is high in any cycle. A cycle with no request produces no select in the cycle after it.
- R10: `mem_we` is high in the response cycle of a write that reached a target. `cpu_rdata` carries the selected target's read data (SFR, RAM or extended RAM), and 0 when nothing is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | Access request this cycle |
| cpu_we | input | 1 | Request is a write |
| cpu_addr | input | 16 | Data-space byte address |
| win_cfg_wr | input | 1 | Load the window configuration |
| win_cfg_prog | input | 1 | New window mode: 0 extended RAM, 1 program view |
| win_cfg_page | input | PAGE_W | New window page number |
| sfr_sel | output | 1 | Peripheral register bank selected |
| ram_sel | output | 1 | Direct RAM selected |
| xram_sel | output | 1 | Extended RAM selected |
| pgm_sel | output | 1 | Program memory selected (read only) |
| mem_we | output | 1 | Write enable to the selected target |
| phys_addr | output | PAGE_W+15 | Translated physical byte address |
| wr_err | output | 1 | Write to read-only window was dropped |
| sfr_rdata | input | DATA_W | Read data from peripheral registers |
| ram_rdata | input | DATA_W | Read data from direct RAM |
| xram_rdata | input | DATA_W | Read data from extended RAM |
| pgm_rdata | input | PROG_W | Instruction word from program memory |
| cpu_rdata | output | DATA_W | Read data returned to the CPU |

## Verification
The hardest case to reach from the ports is a configuration write landing in the same cycle as a window access. Here the old mode and page must win, and the new ones must take effect on the very next request. The stimulus covers this in two ways. A directed sequence pairs a mode flip with a window read, then repeats the read. The random phase also applies configuration writes on about a quarter of its requests, so the collision occurs many times, across both mode directions and random pages. The bench model always uses the pre-update setting for that request.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
   localparam int ADDR_W = 16;
   localparam int WIN_OFS_W = ADDR_W - 1;

   typedef enum logic [2:0] {
      TGT_NONE = 3'd0,
      TGT_SFR  = 3'd1,
      TGT_RAM  = 3'd2,
      TGT_XRAM = 3'd3,
      TGT_PGM  = 3'd4
   } tgt_e;
endpackage

// File: rtl/dsm_win_cfg.sv
module dsm_win_cfg #(
   parameter int PAGE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic              cfg_prog,
   input  logic [PAGE_W-1:0] cfg_page,
   output logic              win_prog,
   output logic [PAGE_W-1:0] win_page
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_prog <= 1'b0;
         win_page <= '0;
      end else if (cfg_wr) begin
         win_prog <= cfg_prog;
         win_page <= cfg_page;
      end
   end

   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_wr |=> ($stable(win_prog) && $stable(win_page))); // R8
endmodule

// File: rtl/dsm_access_stage.sv
module dsm_access_stage
   import dsm_pkg::*;
#(
   parameter int PAGE_W    = 8,
   parameter int SFR_BYTES = 2048,
   localparam int PHYS_W   = PAGE_W + WIN_OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic              win_prog,
   input  logic [PAGE_W-1:0] win_page,
   output tgt_e              tgt_q,
   output logic [PHYS_W-1:0] phys_q,
   output logic              we_q,
   output logic              err_q,
   output logic              lane_q
);
   localparam logic [ADDR_W-1:0] SFR_LAST = ADDR_W'(SFR_BYTES - 1);

   tgt_e              tgt_d;
   logic [PHYS_W-1:0] phys_d;
   logic              err_d;
   logic              in_win;

   assign in_win = addr[ADDR_W-1];

   always_comb begin
      tgt_d  = TGT_NONE;
      err_d  = 1'b0;
      phys_d = {{PAGE_W{1'b0}}, addr[WIN_OFS_W-1:0]};
      if (req) begin
         if (!in_win) begin
            tgt_d = (addr <= SFR_LAST) ? TGT_SFR : TGT_RAM;
         end else begin
            phys_d = {win_page, addr[WIN_OFS_W-1:0]};
            if (!win_prog)  tgt_d = TGT_XRAM;
            else if (we)    err_d = 1'b1;
            else            tgt_d = TGT_PGM;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tgt_q  <= TGT_NONE;
         phys_q <= '0;
         we_q   <= 1'b0;
         err_q  <= 1'b0;
         lane_q <= 1'b0;
      end else begin
         tgt_q  <= tgt_d;
         phys_q <= phys_d;
         we_q   <= we && (tgt_d != TGT_NONE);
         err_q  <= err_d;
         lane_q <= addr[1];
      end
   end

   AST_ERR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |-> (tgt_q == TGT_NONE && !we_q)); // R7
   AST_PGM_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_q == TGT_PGM) |-> !we_q); // R5
   AST_LOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !addr[ADDR_W-1]) |=> (tgt_q == TGT_SFR || tgt_q == TGT_RAM)); // R3
   AST_WIN_HALF: assert property (@(posedge clk) disable iff (!rst_n)
      (req && addr[ADDR_W-1]) |=> (tgt_q == TGT_XRAM || tgt_q == TGT_PGM || err_q)); // R4
endmodule

// File: rtl/dsm_rdata_route.sv
module dsm_rdata_route
   import dsm_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int PROG_W = 24
) (
   input  tgt_e              tgt,
   input  logic              lane,
   input  logic [DATA_W-1:0] sfr_rdata,
   input  logic [DATA_W-1:0] ram_rdata,
   input  logic [DATA_W-1:0] xram_rdata,
   input  logic [PROG_W-1:0] pgm_rdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int HI_W = PROG_W - DATA_W;

   logic [DATA_W-1:0] pgm_hi;

   generate
      if (HI_W < DATA_W) begin : g_pad_hi
         assign pgm_hi = {{(DATA_W - HI_W){1'b0}}, pgm_rdata[PROG_W-1:DATA_W]};
      end else begin : g_full_hi
         assign pgm_hi = pgm_rdata[DATA_W +: DATA_W];
      end
   endgenerate

   always_comb begin
      unique case (tgt)
         TGT_SFR:  rdata = sfr_rdata;
         TGT_RAM:  rdata = ram_rdata;
         TGT_XRAM: rdata = xram_rdata;
         TGT_PGM:  rdata = lane ? pgm_hi : pgm_rdata[DATA_W-1:0];
         default:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/dspace_mapper.sv
module dspace_mapper
   import dsm_pkg::*;
#(
   parameter int PAGE_W    = 8,
   parameter int DATA_W    = 16,
   parameter int PROG_W    = 24,
   parameter int SFR_BYTES = 2048,
   localparam int PHYS_W   = PAGE_W + WIN_OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [15:0]       cpu_addr,
   input  logic              win_cfg_wr,
   input  logic              win_cfg_prog,
   input  logic [PAGE_W-1:0] win_cfg_page,
   output logic              sfr_sel,
   output logic              ram_sel,
   output logic              xram_sel,
   output logic              pgm_sel,
   output logic              mem_we,
   output logic [PHYS_W-1:0] phys_addr,
   output logic              wr_err,
   input  logic [DATA_W-1:0] sfr_rdata,
   input  logic [DATA_W-1:0] ram_rdata,
   input  logic [DATA_W-1:0] xram_rdata,
   input  logic [PROG_W-1:0] pgm_rdata,
   output logic [DATA_W-1:0] cpu_rdata
);
   initial begin
      if (PAGE_W < 1 || PAGE_W > 16)
         $error("dspace_mapper: PAGE_W out of range");
      if (PROG_W <= DATA_W || PROG_W > 2 * DATA_W)
         $error("dspace_mapper: PROG_W must lie in (DATA_W, 2*DATA_W]");
      if (SFR_BYTES < 2 || SFR_BYTES > 32768 || (SFR_BYTES & (SFR_BYTES - 1)) != 0)
         $error("dspace_mapper: SFR_BYTES must be a power of two within the low half");
   end

   logic              win_prog;
   logic [PAGE_W-1:0] win_page;
   tgt_e              tgt_q;
   logic              lane_q;

   dsm_win_cfg #(.PAGE_W(PAGE_W)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_wr   (win_cfg_wr),
      .cfg_prog (win_cfg_prog),
      .cfg_page (win_cfg_page),
      .win_prog (win_prog),
      .win_page (win_page)
   );

   dsm_access_stage #(.PAGE_W(PAGE_W), .SFR_BYTES(SFR_BYTES)) u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (cpu_req),
      .we       (cpu_we),
      .addr     (cpu_addr),
      .win_prog (win_prog),
      .win_page (win_page),
      .tgt_q    (tgt_q),
      .phys_q   (phys_addr),
      .we_q     (mem_we),
      .err_q    (wr_err),
      .lane_q   (lane_q)
   );

   dsm_rdata_route #(.DATA_W(DATA_W), .PROG_W(PROG_W)) u_route (
      .tgt        (tgt_q),
      .lane       (lane_q),
      .sfr_rdata  (sfr_rdata),
      .ram_rdata  (ram_rdata),
      .xram_rdata (xram_rdata),
      .pgm_rdata  (pgm_rdata),
      .rdata      (cpu_rdata)
   );

   assign sfr_sel  = (tgt_q == TGT_SFR);
   assign ram_sel  = (tgt_q == TGT_RAM);
   assign xram_sel = (tgt_q == TGT_XRAM);
   assign pgm_sel  = (tgt_q == TGT_PGM);

   AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sfr_sel, ram_sel, xram_sel, pgm_sel})); // R9
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_req |=> !(sfr_sel || ram_sel || xram_sel || pgm_sel || mem_we || wr_err)); // R9
   AST_WE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (sfr_sel || ram_sel || xram_sel)); // R10
   AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_err && !$past(cpu_req)) |-> 1'b0); // R7
endmodule

// File: tb/dspace_mapper_test.sv
`timescale 1ns/1ps
module dspace_mapper_test;
   localparam int PAGE_W = 8;
   localparam int PHYS_W = PAGE_W + 15;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cpu_req = 1'b0, cpu_we = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic win_cfg_wr = 1'b0, win_cfg_prog = 1'b0;
   logic [PAGE_W-1:0] win_cfg_page = '0;
   logic sfr_sel, ram_sel, xram_sel, pgm_sel, mem_we, wr_err;
   logic [PHYS_W-1:0] phys_addr;
   logic [15:0] sfr_rdata, ram_rdata, xram_rdata, cpu_rdata;
   logic [23:0] pgm_rdata;

   int n_tests = 0;
   int n_fail = 0;
   logic m_prog = 1'b0;
   logic [PAGE_W-1:0] m_page = '0;

   always #5 clk = ~clk;

   function automatic logic [15:0] f_sfr(input logic [PHYS_W-1:0] p);
      return p[15:0] ^ 16'h5A00;
   endfunction
   function automatic logic [15:0] f_ram(input logic [PHYS_W-1:0] p);
      return p[15:0] ^ 16'h0F0F;
   endfunction
   function automatic logic [15:0] f_xram(input logic [PHYS_W-1:0] p);
      return p[15:0] ^ {p[22:15], 8'h3C};
   endfunction
   function automatic logic [23:0] f_pgm(input logic [PHYS_W-1:0] p);
      return {p[22:15] ^ p[7:0], p[15:0] ^ 16'hC3C3};
   endfunction

   assign sfr_rdata  = f_sfr(phys_addr);
   assign ram_rdata  = f_ram(phys_addr);
   assign xram_rdata = f_xram(phys_addr);
   assign pgm_rdata  = f_pgm(phys_addr);

   dspace_mapper #(.PAGE_W(PAGE_W)) uut (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .win_cfg_wr(win_cfg_wr), .win_cfg_prog(win_cfg_prog), .win_cfg_page(win_cfg_page),
      .sfr_sel(sfr_sel), .ram_sel(ram_sel), .xram_sel(xram_sel), .pgm_sel(pgm_sel),
      .mem_we(mem_we), .phys_addr(phys_addr), .wr_err(wr_err),
      .sfr_rdata(sfr_rdata), .ram_rdata(ram_rdata), .xram_rdata(xram_rdata),
      .pgm_rdata(pgm_rdata), .cpu_rdata(cpu_rdata)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Drives one request at a negedge, optionally with a config write in the same cycle,
   // then checks the response one clock later at the following negedge.
   task automatic access(input logic we, input logic [15:0] a, input logic do_cfg,
                         input logic cp, input logic [PAGE_W-1:0] cpg, input string tag);
      logic [3:0] e_sel;
      logic [PHYS_W-1:0] e_phys;
      logic e_err, e_we;
      logic [15:0] e_rd;
      string rtag;
      e_sel = 4'b0000; e_err = 1'b0; e_rd = 16'h0;
      e_phys = {{PAGE_W{1'b0}}, a[14:0]};
      rtag = "R10";
      if (!a[15]) begin
         e_sel = (a < 16'h0800) ? 4'b1000 : 4'b0100;
      end else begin
         e_phys = {m_page, a[14:0]};
         if (!m_prog) e_sel = 4'b0010;
         else if (we) e_err = 1'b1;
         else e_sel = 4'b0001;
      end
      e_we = we && (e_sel != 4'b0000);
      case (e_sel)
         4'b1000: e_rd = f_sfr(e_phys);
         4'b0100: e_rd = f_ram(e_phys);
         4'b0010: e_rd = f_xram(e_phys);
         4'b0001: begin
            e_rd = a[1] ? {8'h00, f_pgm(e_phys)[23:16]} : f_pgm(e_phys)[15:0];
            rtag = "R6";
         end
         default: e_rd = 16'h0;
      endcase
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a;
      win_cfg_wr = do_cfg; win_cfg_prog = cp; win_cfg_page = cpg;
      @(posedge clk);
      @(negedge clk);
      cpu_req = 1'b0; cpu_we = 1'b0; win_cfg_wr = 1'b0;
      if (do_cfg) begin m_prog = cp; m_page = cpg; end
      check({tag, " select"}, 64'({sfr_sel, ram_sel, xram_sel, pgm_sel}), 64'(e_sel));
      check({tag, " phys_addr"}, 64'(phys_addr), 64'(e_phys));
      check({tag, " we/err"}, 64'({mem_we, wr_err}), 64'({e_we, e_err}));
      if (!we) check({rtag, " read data"}, 64'(cpu_rdata), 64'(e_rd));
   endtask

   initial begin
      #2_000_000;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd1977));
      repeat (3) @(negedge clk);
      // R1: outputs quiet during reset
      check("R1 reset outputs",
            64'({sfr_sel, ram_sel, xram_sel, pgm_sel, mem_we, wr_err, cpu_rdata}), 64'(0));
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", 64'({sfr_sel, ram_sel, xram_sel, pgm_sel, mem_we, wr_err}), 64'(0));
      // R1: window starts as extended RAM on page 0
      access(1'b0, 16'h9234, 1'b0, 1'b0, '0, "R1 window default");
      // R2 / R3 boundaries
      access(1'b0, 16'h0000, 1'b0, 1'b0, '0, "R2 sfr low");
      access(1'b1, 16'h07FF, 1'b0, 1'b0, '0, "R2 sfr top");
      access(1'b0, 16'h0800, 1'b0, 1'b0, '0, "R3 ram bottom");
      access(1'b1, 16'h7FFF, 1'b0, 1'b0, '0, "R3 ram top");
      // R4: extended RAM page
      access(1'b0, 16'h8000, 1'b1, 1'b0, 8'h05, "R4 xram old page");
      access(1'b1, 16'hFFFE, 1'b0, 1'b0, '0, "R4 xram write page5");
      // R8: mode flip in same cycle as window read uses old mode
      access(1'b0, 16'h8002, 1'b1, 1'b1, 8'h03, "R8 same-cycle cfg");
      // R5 / R6: program view, both lanes
      access(1'b0, 16'h8002, 1'b0, 1'b0, '0, "R5 pgm upper lane");
      access(1'b0, 16'h8000, 1'b0, 1'b0, '0, "R5 pgm lower lane");
      // R7: write into program view dropped
      access(1'b1, 16'hFFFE, 1'b0, 1'b0, '0, "R7 pgm write");
      // R8: flip back to extended RAM, next request sees it
      access(1'b1, 16'hC000, 1'b1, 1'b0, 8'h7F, "R8 cfg with dropped write");
      access(1'b1, 16'hC000, 1'b0, 1'b0, '0, "R8 new page active");
      // R9: idle cycle selects nothing
      @(negedge clk);
      check("R9 idle", 64'({sfr_sel, ram_sel, xram_sel, pgm_sel, mem_we, wr_err}), 64'(0));
      check("R10 idle rdata", 64'(cpu_rdata), 64'(0));
      // Random mix with frequent same-cycle config writes
      for (int i = 0; i < 600; i++) begin
         logic [15:0] ra;
         logic rw, rc;
         ra = 16'($urandom);
         if ($urandom_range(0, 3) == 0) ra = {1'b0, 4'b0000, ra[10:0]};
         rw = ($urandom_range(0, 2) == 0);
         rc = ($urandom_range(0, 3) == 0);
         access(rw, ra, rc, 1'($urandom), PAGE_W'($urandom), "R4 random");
         if ($urandom_range(0, 7) == 0) begin
            @(negedge clk);
            check("R9 random idle",
                  64'({sfr_sel, ram_sel, xram_sel, pgm_sel, mem_we, wr_err}), 64'(0));
         end
      end
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule